// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Code Register

This block is the digital front end of a four-channel, 8-bit converter. A single shared 8-bit bus writes one of four input latches. A 2-bit channel select picks the latch, and an active-low write strobe opens it. A common load control then moves the input latches into the four DAC code registers. Only the DAC code registers reach the outputs, so a host can stage new codes on every channel and then make them visible together.

The storage is level-transparent and is modelled in one clock domain. While the write strobe is low, the selected input latch follows the bus. While the load control is low, every DAC register follows its own input latch one clock later. When the load control rises, all four DAC registers capture their latches in the same cycle and then freeze until the load control falls again.

The load control is asynchronous to writes. A timing guard therefore checks one rule: when a write ends while the load control is low, the load control must stay low for a parameterised number of clock cycles. If it rises too early, a sticky error flag is raised.

Top module: `dac_quad_front`

## Requirements
- R1: A synchronous reset clears all four input latches, all four DAC registers and the error flag. After reset every output code reads 0x00.
- R2: While `writeN` is low at a clock edge, the input latch chosen by `chanSel` takes `dataIn`. The select values are 0 for channel A, 1 for channel B, 2 for channel C and 3 for channel D. Channel A occupies `chanCodes[7:0]`, B `[15:8]`, C `[23:16]` and D `[31:24]`, and bit 7 of each code is its MSB.
- R3: A write never alters the input latches of the three unselected channels.
- R4: While `writeN` stays low over several edges, the selected latch follows the bus. When `writeN` goes high, the latch keeps the last value it took.
- R5: While `loadDac` is low, each output code equals its input latch as it stood one clock earlier.
- R6: At the first edge where `loadDac` is high, all four DAC registers capture their input latches. They then hold while `loadDac` stays high, and writes made during that time leave every output unchanged.
- R7: Once `loadDac` returns low, staged latch contents reach the outputs one clock later.
- R8: A write ends when `writeN` is sampled high after being low, with `loadDac` low. If `loadDac` is then sampled high within `HOLD_CYC` cycles after that edge, `holdErr` is set, and it stays set until reset.
- R9: `holdErr` stays clear in two cases. The first is when `loadDac` rises only after `HOLD_CYC` further low cycles. The second is when the write ended while `loadDac` was already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Shared data bus, bit 7 is MSB |
| chanSel | input | 2 | Channel select for writes (0=A .. 3=D) |
| writeN | input | 1 | Active-low write strobe, level sensitive |
| loadDac | input | 1 | Common load control: low passes through, rising captures, high holds |
| chanCodes | output | 32 | Four DAC register codes, channel A in the low byte |
| holdErr | output | 1 | Sticky flag for a load rise inside the hold window |

## Verification
A stimulus table interleaves four phases:
- writes to all four channels with load held high, then a single load;
- writes made with load low;
- a multi-cycle write whose data changes on every edge;
- writes made while load stays high.

A cycle-level reference model is compared against these phases. It separates a correct capture-then-hold from plain pass-through, and a correct channel decode from writes that leak into other channels. Directed sequences then place the load rise one cycle after a write ends, exactly at the last cycle of the window, and one cycle past it. They also end a write while load is already high, which shows whether the error guard is armed only by the right event. A final reset from a fully populated state confirms that every stage is cleared.

// File: rtl/dacq_pkg.sv
package dacq_pkg;
  localparam int NUM_CH = 4;
  localparam int SEL_W  = $clog2(NUM_CH);

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] latchEn;  // one per input latch, at most one set
    logic              dacPass;  // DAC registers take their latches this cycle
  } dacq_strobe_t;
endpackage

// File: rtl/dacq_chan.sv
module dacq_chan #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latchEn,
  input  logic              dacPass,
  input  logic [CODE_W-1:0] dataIn,
  output logic [CODE_W-1:0] latchQ,
  output logic [CODE_W-1:0] dacQ
);
  // first rank: input latch, open while its write enable is high
  always_ff @(posedge clk) begin
    if (rst) begin
      latchQ <= '0;
    end else if (latchEn) begin
      latchQ <= dataIn;
    end
  end

  // second rank: DAC register, fed from the first rank's previous value
  always_ff @(posedge clk) begin
    if (rst) begin
      dacQ <= '0;
    end else if (dacPass) begin
      dacQ <= latchQ;
    end
  end
endmodule

// File: rtl/dacq_ctrl.sv
module dacq_ctrl
  import dacq_pkg::*;
#(
  parameter int HOLD_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             writeN,
  input  logic [SEL_W-1:0] chanSel,
  input  logic             loadDac,
  output dacq_strobe_t     strobes,
  output logic             holdErr
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC);

  logic             prevLoad;
  logic             prevWriteN;
  logic [CNT_W-1:0] holdCnt;
  logic             holdErrQ;
  logic             loadRise;
  logic             wrRise;

  assign loadRise = loadDac & ~prevLoad;
  assign wrRise   = writeN & ~prevWriteN;

  // address decode: one enable per channel
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign strobes.latchEn[i] = ~writeN && (chanSel == SEL_W'(i));
  end

  // transparent while low, capture on the first high cycle
  assign strobes.dacPass = ~loadDac | loadRise;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLoad   <= 1'b0;
      prevWriteN <= 1'b1;
      holdCnt    <= '0;
      holdErrQ   <= 1'b0;
    end else begin
      prevLoad   <= loadDac;
      prevWriteN <= writeN;
      if (loadDac) begin
        holdCnt <= '0;
      end else if (wrRise) begin
        holdCnt <= HOLD_LD;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
      if (loadDac && (holdCnt != '0)) begin
        holdErrQ <= 1'b1;
      end
    end
  end

  assign holdErr = holdErrQ;
endmodule

// File: rtl/dacq_datapath.sv
module dacq_datapath
  import dacq_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CODE_W-1:0]        dataIn,
  input  dacq_strobe_t             strobes,
  output logic [NUM_CH*CODE_W-1:0] latchCodes,
  output logic [NUM_CH*CODE_W-1:0] chanCodes
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dacq_chan #(.CODE_W(CODE_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .latchEn (strobes.latchEn[i]),
      .dacPass (strobes.dacPass),
      .dataIn  (dataIn),
      .latchQ  (latchCodes[i*CODE_W +: CODE_W]),
      .dacQ    (chanCodes[i*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dac_quad_front.sv
module dac_quad_front
  import dacq_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int HOLD_CYC = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CODE_W-1:0]        dataIn,
  input  logic [SEL_W-1:0]         chanSel,
  input  logic                     writeN,
  input  logic                     loadDac,
  output logic [NUM_CH*CODE_W-1:0] chanCodes,
  output logic                     holdErr
);
  dacq_strobe_t              strobes;
  logic [NUM_CH*CODE_W-1:0]  latchCodes;

  dacq_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .writeN  (writeN),
    .chanSel (chanSel),
    .loadDac (loadDac),
    .strobes (strobes),
    .holdErr (holdErr)
  );

  dacq_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .dataIn     (dataIn),
    .strobes    (strobes),
    .latchCodes (latchCodes),
    .chanCodes  (chanCodes)
  );
endmodule

// File: rtl/dac_quad_front_chk.sv
module dac_quad_front_chk
  import dacq_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [CODE_W-1:0]        dataIn,
  input logic [SEL_W-1:0]         chanSel,
  input logic                     writeN,
  input logic                     loadDac,
  input dacq_strobe_t             strobes,
  input logic [NUM_CH*CODE_W-1:0] latchCodes,
  input logic [NUM_CH*CODE_W-1:0] chanCodes,
  input logic                     holdErr
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (chanCodes == '0) && (latchCodes == '0) && !holdErr);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    !writeN |=> latchCodes[$past(chanSel)*CODE_W +: CODE_W] == $past(dataIn));

  // R3
  one_latch_open_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes.latchEn));

  // R4
  idle_bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    writeN |=> $stable(latchCodes));

  // R5
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadDac && !$past(rst)) |=> chanCodes == $past(latchCodes));

  // R6
  frozen_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    (loadDac && $past(loadDac) && !$past(rst)) |=> $stable(chanCodes));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    holdErr |=> holdErr);

  // R8
  err_on_load_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(holdErr) |-> ($past(loadDac) && !$past(rst)));
endmodule

bind dac_quad_front dac_quad_front_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dataIn     (dataIn),
  .chanSel    (chanSel),
  .writeN     (writeN),
  .loadDac    (loadDac),
  .strobes    (strobes),
  .latchCodes (latchCodes),
  .chanCodes  (chanCodes),
  .holdErr    (holdErr)
);

// File: tb/dac_quad_front_bench.sv
module dac_quad_front_bench;
  localparam int CODE_W = 8;
  localparam int NCH    = 4;
  localparam int NVEC   = 26;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CODE_W-1:0] dataIn = '0;
  logic [1:0]        chanSel = '0;
  logic              writeN = 1'b1;
  logic              loadDac = 1'b0;
  logic [NCH*CODE_W-1:0] chanCodes;
  logic              holdErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference state
  logic [CODE_W-1:0] mLatch [NCH];
  logic [CODE_W-1:0] mDac   [NCH];
  logic              mPrevLoad;

  always #4 clk = ~clk;

  dac_quad_front #(.CODE_W(CODE_W), .HOLD_CYC(3)) u_dac_quad_front (
    .clk       (clk),
    .rst       (rst),
    .dataIn    (dataIn),
    .chanSel   (chanSel),
    .writeN    (writeN),
    .loadDac   (loadDac),
    .chanCodes (chanCodes),
    .holdErr   (holdErr)
  );

  // {writeN, chanSel, data, load}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 8'h11, 1'b1}, {1'b0, 2'd1, 8'h22, 1'b1},
    {1'b0, 2'd2, 8'h33, 1'b1}, {1'b0, 2'd3, 8'h44, 1'b1},
    {1'b1, 2'd0, 8'h00, 1'b1}, {1'b1, 2'd0, 8'h00, 1'b0},
    {1'b1, 2'd0, 8'h00, 1'b0}, {1'b1, 2'd0, 8'h00, 1'b1},
    {1'b0, 2'd1, 8'h5A, 1'b1}, {1'b0, 2'd1, 8'h5B, 1'b1},
    {1'b1, 2'd1, 8'hFF, 1'b1}, {1'b1, 2'd2, 8'hEE, 1'b1},
    {1'b1, 2'd0, 8'h00, 1'b0}, {1'b1, 2'd0, 8'h00, 1'b0},
    {1'b0, 2'd2, 8'hC3, 1'b0}, {1'b1, 2'd2, 8'h00, 1'b0},
    {1'b1, 2'd0, 8'h00, 1'b0}, {1'b0, 2'd3, 8'h80, 1'b0},
    {1'b0, 2'd0, 8'h01, 1'b1}, {1'b1, 2'd0, 8'h00, 1'b1},
    {1'b0, 2'd2, 8'h7E, 1'b1}, {1'b1, 2'd0, 8'h00, 1'b1},
    {1'b1, 2'd0, 8'h00, 1'b0}, {1'b1, 2'd0, 8'h00, 1'b0},
    {1'b0, 2'd0, 8'hA5, 1'b0}, {1'b1, 2'd0, 8'h00, 1'b0}
  };

  function automatic logic [NCH*CODE_W-1:0] modelCodes();
    logic [NCH*CODE_W-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*CODE_W +: CODE_W] = mDac[i];
    return v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NCH; i++) begin
      mLatch[i] = '0;
      mDac[i]   = '0;
    end
    mPrevLoad = 1'b0;
  endtask

  task automatic modelStep(input logic wN, input logic [1:0] s,
                           input logic [CODE_W-1:0] d, input logic ld);
    if (!ld || !mPrevLoad) begin
      for (int i = 0; i < NCH; i++) mDac[i] = mLatch[i];
    end
    if (!wN) mLatch[s] = d;
    mPrevLoad = ld;
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [NCH*CODE_W-1:0] act,
                       input logic [NCH*CODE_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic wN, input logic [1:0] s,
                      input logic [CODE_W-1:0] d, input logic ld);
    writeN = wN; chanSel = s; dataIn = d; loadDac = ld;
    @(posedge clk);
    if (rst) modelReset();
    else modelStep(wN, s, d, ld);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    step(1'b1, 2'd0, '0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic checkCodes(input string tag);
    check(chanCodes == modelCodes(), tag, chanCodes, modelCodes());
  endtask

  task automatic checkErr(input logic exp, input string tag);
    check(holdErr == exp, tag, {{(NCH*CODE_W-1){1'b0}}, holdErr},
          {{(NCH*CODE_W-1){1'b0}}, exp});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired R1 actual=running expected=done");
    finishRun();
  end

  initial begin
    modelReset();
    @(negedge clk);
    doReset();
    // R1 reset state
    check(chanCodes == '0, "R1 codes after reset", chanCodes, '0);
    checkErr(1'b0, "R1 flag after reset");

    // table walk: R2 R3 R4 R5 R6 R7 against the reference
    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][11], VEC[v][10:9], VEC[v][8:1], VEC[v][0]);
      checkCodes("R2 R3 R4 R5 R6 R7 table");
    end

    // R6 writes during a long high load leave outputs frozen
    doReset();
    step(1'b1, 2'd0, '0, 1'b1);
    step(1'b0, 2'd3, 8'h9C, 1'b1);
    step(1'b0, 2'd0, 8'h3C, 1'b1);
    step(1'b1, 2'd0, 8'h00, 1'b1);
    check(chanCodes == '0, "R6 frozen while load high", chanCodes, '0);
    // R7 release: one cycle later the staged values appear
    step(1'b1, 2'd0, 8'h00, 1'b0);
    check(chanCodes == 32'h9C00_003C, "R7 release", chanCodes, 32'h9C00_003C);

    // R8 load rises one cycle after the write ends
    doReset();
    step(1'b0, 2'd0, 8'hAA, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b1);
    checkErr(1'b1, "R8 early load rise");
    step(1'b1, 2'd0, 8'h00, 1'b1);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    checkErr(1'b1, "R8 flag sticky");
    checkCodes("R5 data after violation run");

    // R8 rise at the last cycle inside the window
    doReset();
    step(1'b0, 2'd1, 8'h12, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    checkErr(1'b0, "R8 clear while load still low");
    step(1'b1, 2'd0, 8'h00, 1'b1);
    checkErr(1'b1, "R8 boundary rise inside window");

    // R9 rise one cycle past the window
    doReset();
    step(1'b0, 2'd1, 8'h34, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b1);
    checkErr(1'b0, "R9 rise after window");
    check(chanCodes == 32'h0000_3400, "R9 codes after clean load",
          chanCodes, 32'h0000_3400);

    // R9 write ending while load is already high does not arm the guard
    doReset();
    step(1'b1, 2'd0, 8'h00, 1'b1);
    step(1'b0, 2'd2, 8'h56, 1'b1);
    step(1'b1, 2'd0, 8'h00, 1'b1);
    step(1'b1, 2'd0, 8'h00, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b1);
    checkErr(1'b0, "R9 write ended under high load");
    check(chanCodes == 32'h0056_0000, "R9 codes", chanCodes, 32'h0056_0000);

    // R1 reset from a populated state
    step(1'b0, 2'd0, 8'hF0, 1'b0);
    step(1'b1, 2'd0, 8'h00, 1'b1);
    step(1'b1, 2'd0, 8'h00, 1'b1);
    doReset();
    check(chanCodes == '0, "R1 codes cleared", chanCodes, '0);
    checkErr(1'b0, "R1 flag cleared");
    step(1'b1, 2'd0, 8'h00, 1'b0);
    check(chanCodes == '0, "R1 latches cleared", chanCodes, '0);

    finishRun();
  end
endmodule